// File: doc/BRIEF.md
# SPI Register Bank Slave

This block is an SPI slave (clock idle low, MOSI captured on the rising SCLK edge, MISO changed after the falling edge) that gives a host access to a small bank of 16-bit configuration and status registers. Every transaction is a 24-bit frame sent most significant bit first. Bit 23 selects read (1) or write (0). Bits 22:17 hold a 6-bit register address, bits 16:1 hold the data word and bit 0 is spare. On a read, the addressed register leaves MISO in frame bit positions 16:1 of the same frame. A write takes effect when chip select is released after exactly 24 clocks. The SPI pins are brought into the system clock domain through a synchronizer with a parameterised number of stages. All frame handling runs on the system clock.

The register set contains several entries. An identity/control word has a parity enable and a soft reset, and reads back a fixed device number and a revision. A sticky alarm word flags bad parity, too few clocks, too many clocks and unmapped addresses, and a mask word selects which of those alarms raise `alarm_irq`. A nine-bit function enable word drives `func_en`. There are also a linearizer setting, an LO path word with a sideband bit and two 4-bit phase trims, and a converter control word. A modelled converter captures `det_level` a programmable number of clocks after it is armed. Its result appears, with a done flag, in a read-only output word.

A five-state machine tracks each frame. IDLE goes to HEAD when chip select becomes active. HEAD goes to BODY on the seventh rising SCLK edge, once the read flag and the address are known. BODY goes to FULL on the 24th rising edge. FULL goes to LONG on any further rising edge. Releasing chip select in any state other than IDLE returns the machine to IDLE and reports one event. That event is "good" from FULL, "long" from LONG, and "short" from HEAD or BODY.

Top module: `spi_rb_slave`

## Requirements
- R1: A frame is accepted only when chip select is released after exactly 24 rising SCLK edges. MOSI is taken MSB first: bit 23 = 1 means read, bits 22:17 are the address, bits 16:1 are the data.
- R2: On a read frame, MISO carries the addressed register's 16-bit value MSB first during frame bits 16:1. MISO is 0 at every other point of the frame and while chip select is released.
- R3: Address 0x00 has a writable parity enable in bit 15 and a writable soft reset in bit 14. Bits 11:4 read 0x0A, bits 3:0 read the REVISION parameter and bits 13:12 read 0.
- R4: A frame released after fewer than 24 rising edges sets alarm bit 14 (address 0x01) and changes no other register.
- R5: A frame with more than 24 rising edges sets alarm bit 13 and changes no other register.
- R6: A complete frame whose address is not 0x00–0x06 or 0x0C sets alarm bit 12 and changes no other register. A read of such an address returns 0.
- R7: While parity enable is 1, a complete frame with an even number of ones across its 24 bits sets alarm bit 15 and writes nothing.
- R8: Alarm bits 15:12 are cleared by writing 1s to the same positions of 0x01. Bits 15:12 of 0x02 mask the corresponding alarms, and `alarm_irq` is 1 while any unmasked alarm is set.
- R9: Bits 8:0 of address 0x03 drive `func_en`. Writing 0 there drives every enable low.
- R10: The writable fields are 0x02 bits 15:12, 0x04 bits 7:0, 0x05 bits 10 and 7:0, and 0x06 bits 3:0. Other bits read 0, and writes to 0x0C are ignored.
- R11: While soft reset reads 1, every register other than 0x00 is held at 0: writes to it are ignored and no alarm is recorded.
- R12: When 0x06 bits 2:0 (start, converter enable, converter clock enable) all become 1, 0x0C bit 8 (done) rises CONV_CYCLES+1 clocks after the write and not before. Bits 7:0 then hold `det_level` as sampled at that moment.
- R13: Clearing start keeps done and the result readable. Arming again clears done but keeps the old result until the new conversion finishes.
- R14: After reset, every register reads 0 apart from the identity fields, and `func_en`, `alarm_irq` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| det_level | input | 8 | Detector level captured by the modelled converter |
| func_en | output | 9 | Function enables from register 0x03 |
| alarm_irq | output | 1 | Any unmasked alarm set |

## Verification
The hardest situations to reach from the pins are malformed frames and the soft-reset window. The bench builds every frame bit by bit, so it can release chip select after any count of clocks, add a 25th clock, or choose a word with even parity. It then reads the alarm word and watches `func_en` to show that nothing else moved. Soft reset is driven through its own register and followed by writes and a short frame that must leave no trace. For the converter, the bench arms it and reads 0x0C at once, within the conversion window, before waiting out the conversion.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    localparam int FRAME_BITS = 24;
    localparam int HEAD_BITS  = 7;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        FS_IDLE, FS_HEAD, FS_BODY, FS_FULL, FS_LONG
    } frame_state_e;

    typedef enum logic [1:0] {
        EV_GOOD, EV_SHORT, EV_LONG
    } evt_kind_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_ALARM = 6'h01;
    localparam logic [ADDR_W-1:0] A_MASK  = 6'h02;
    localparam logic [ADDR_W-1:0] A_ENA   = 6'h03;
    localparam logic [ADDR_W-1:0] A_LIN   = 6'h04;
    localparam logic [ADDR_W-1:0] A_LO    = 6'h05;
    localparam logic [ADDR_W-1:0] A_ADCC  = 6'h06;
    localparam logic [ADDR_W-1:0] A_ADCO  = 6'h0C;

    localparam logic [7:0] DEVICE_ID = 8'h0A;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;
    localparam logic [2:0] PIPE_RST = 3'b010;  // {sclk, cs_n, mosi}

    logic [2:0] pipe [STAGES];
    logic       sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= PIPE_RST;
            sclk_d <= 1'b0;
        end else begin
            pipe[0] <= {sclk, cs_n, mosi};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sclk_d <= pipe[LAST][2];
        end
    end

    assign sclk_rise = pipe[LAST][2] & ~sclk_d;
    assign sclk_fall = ~pipe[LAST][2] & sclk_d;
    assign cs_active = ~pipe[LAST][1];
    assign mosi_s    = pipe[LAST][0];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_active,
    input  logic                  mosi_s,
    input  logic [DATA_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  miso,
    output logic                  evt_valid,
    output evt_kind_e             evt_kind,
    output logic [FRAME_BITS-1:0] evt_word
);
    frame_state_e          state, state_nxt;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] sh_in;
    logic [DATA_W-1:0]     sh_out;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_IDLE: if (cs_active) state_nxt = FS_HEAD;
            FS_HEAD: begin
                if (!cs_active) state_nxt = FS_IDLE;
                else if (sclk_rise && bit_cnt == CNT_W'(HEAD_BITS - 1)) state_nxt = FS_BODY;
            end
            FS_BODY: begin
                if (!cs_active) state_nxt = FS_IDLE;
                else if (sclk_rise && bit_cnt == CNT_W'(FRAME_BITS - 1)) state_nxt = FS_FULL;
            end
            FS_FULL: begin
                if (!cs_active) state_nxt = FS_IDLE;
                else if (sclk_rise) state_nxt = FS_LONG;
            end
            FS_LONG: if (!cs_active) state_nxt = FS_IDLE;
            default: state_nxt = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        evt_valid = (state != FS_IDLE) && !cs_active;
        unique case (state)
            FS_FULL: evt_kind = EV_GOOD;
            FS_LONG: evt_kind = EV_LONG;
            default: evt_kind = EV_SHORT;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
        end else if (state == FS_IDLE) begin
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
        end else if (!cs_active) begin
            sh_out  <= '0;
        end else begin
            if (sclk_rise && (state == FS_HEAD || state == FS_BODY)) begin
                sh_in   <= {sh_in[FRAME_BITS-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall) begin
                if (bit_cnt == CNT_W'(HEAD_BITS) && sh_in[HEAD_BITS-1])
                    sh_out <= rd_data;
                else
                    sh_out <= {sh_out[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rd_addr  = sh_in[ADDR_W-1:0];
    assign miso     = sh_out[DATA_W-1];
    assign evt_word = sh_in;
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
    import spi_rb_pkg::*;
#(
    parameter logic [3:0] REVISION    = 4'h3,
    parameter int         CONV_CYCLES = 500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid,
    input  evt_kind_e             evt_kind,
    input  logic [FRAME_BITS-1:0] evt_word,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [7:0]            det_level,
    output logic [DATA_W-1:0]     rd_data,
    output logic [8:0]            func_en,
    output logic                  alarm_irq,
    output logic                  soft_rst,
    output logic                  adc_done,
    output logic                  adc_all_on
);
    localparam int CONV_W = $clog2(CONV_CYCLES + 1);

    logic              ctrl_par, ctrl_srst;
    logic [3:0]        alarm, alarm_nxt, mask;   // {parity, few, many, range}
    logic [8:0]        ena;
    logic [7:0]        lin, lo_ph, adc_res;
    logic              lo_sb;
    logic [3:0]        adcc;
    logic              busy, all_q;
    logic [CONV_W-1:0] conv_cnt;

    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              good_frame, par_bad, do_wr, ctrl_wr, w_mapped;

    function automatic logic mapped(input logic [ADDR_W-1:0] a);
        return (a <= A_ADCC) || (a == A_ADCO);
    endfunction

    function automatic logic [DATA_W-1:0] view(input logic [ADDR_W-1:0] a);
        case (a)
            A_CTRL:  return {ctrl_par, ctrl_srst, 2'b00, DEVICE_ID, REVISION};
            A_ALARM: return {alarm, 12'h000};
            A_MASK:  return {mask, 12'h000};
            A_ENA:   return {7'd0, ena};
            A_LIN:   return {8'd0, lin};
            A_LO:    return {5'd0, lo_sb, 2'b00, lo_ph};
            A_ADCC:  return {12'd0, adcc};
            A_ADCO:  return {7'd0, adc_done, adc_res};
            default: return '0;
        endcase
    endfunction

    assign w_addr     = evt_word[FRAME_BITS-2 -: ADDR_W];
    assign w_data     = evt_word[DATA_W:1];
    assign w_mapped   = mapped(w_addr);
    assign good_frame = evt_valid && evt_kind == EV_GOOD;
    assign par_bad    = ctrl_par && !(^evt_word);
    assign do_wr      = good_frame && !par_bad && !evt_word[FRAME_BITS-1] && w_mapped;
    assign ctrl_wr    = do_wr && w_addr == A_CTRL;

    always_comb begin
        alarm_nxt = alarm;
        if (do_wr && w_addr == A_ALARM) alarm_nxt = alarm & ~w_data[15:12];
        if (evt_valid) begin
            case (evt_kind)
                EV_SHORT: alarm_nxt[2] = 1'b1;
                EV_LONG:  alarm_nxt[1] = 1'b1;
                default: begin
                    if (par_bad)        alarm_nxt[3] = 1'b1;
                    else if (!w_mapped) alarm_nxt[0] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_par <= 1'b0; ctrl_srst <= 1'b0;
            alarm <= '0; mask <= '0; ena <= '0; lin <= '0;
            lo_sb <= 1'b0; lo_ph <= '0; adcc <= '0;
        end else begin
            if (ctrl_wr) {ctrl_par, ctrl_srst} <= w_data[15:14];
            if (ctrl_srst) begin
                alarm <= '0; mask <= '0; ena <= '0; lin <= '0;
                lo_sb <= 1'b0; lo_ph <= '0; adcc <= '0;
            end else begin
                alarm <= alarm_nxt;
                if (do_wr) begin
                    case (w_addr)
                        A_MASK: mask <= w_data[15:12];
                        A_ENA:  ena  <= w_data[8:0];
                        A_LIN:  lin  <= w_data[7:0];
                        A_LO: begin
                            lo_sb <= w_data[10];
                            lo_ph <= w_data[7:0];
                        end
                        A_ADCC: adcc <= w_data[3:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // modelled detector converter
    assign adc_all_on = &adcc[2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; all_q <= 1'b0; conv_cnt <= '0;
            adc_done <= 1'b0; adc_res <= '0;
        end else if (ctrl_srst) begin
            busy <= 1'b0; all_q <= 1'b0; conv_cnt <= '0;
            adc_done <= 1'b0; adc_res <= '0;
        end else begin
            all_q <= adc_all_on;
            if (adc_all_on && !all_q) begin
                busy     <= 1'b1;
                conv_cnt <= '0;
                adc_done <= 1'b0;
            end else if (busy) begin
                if (!adc_all_on) begin
                    busy <= 1'b0;
                end else if (conv_cnt == CONV_W'(CONV_CYCLES - 1)) begin
                    busy     <= 1'b0;
                    adc_done <= 1'b1;
                    adc_res  <= det_level;
                end else begin
                    conv_cnt <= conv_cnt + 1'b1;
                end
            end
        end
    end

    assign rd_data   = view(rd_addr);
    assign func_en   = ena;
    assign alarm_irq = |(alarm & ~mask);
    assign soft_rst  = ctrl_srst;
endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
    import spi_rb_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REVISION    = 4'h3,
    parameter int         CONV_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] det_level,
    output logic [8:0] func_en,
    output logic       alarm_irq
);
    logic                  sclk_rise, sclk_fall, cs_active, mosi_s;
    logic [DATA_W-1:0]     rd_data;
    logic [ADDR_W-1:0]     rd_addr;
    logic                  evt_valid;
    evt_kind_e             evt_kind;
    logic [FRAME_BITS-1:0] evt_word;
    logic                  soft_rst, adc_done, adc_all_on;

    spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_s(mosi_s)
    );

    spi_rb_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_s(mosi_s),
        .rd_data(rd_data), .rd_addr(rd_addr), .miso(spi_miso),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_word(evt_word)
    );

    spi_rb_regs #(.REVISION(REVISION), .CONV_CYCLES(CONV_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_word(evt_word),
        .rd_addr(rd_addr), .det_level(det_level), .rd_data(rd_data),
        .func_en(func_en), .alarm_irq(alarm_irq),
        .soft_rst(soft_rst), .adc_done(adc_done), .adc_all_on(adc_all_on)
    );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_miso,
    input logic       evt_valid,
    input logic       soft_rst,
    input logic       adc_done,
    input logic       adc_all_on,
    input logic       alarm_irq,
    input logic [8:0] func_en
);
    // R2: output shifter is emptied when a frame ends
    a_r2_miso_quiet_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !spi_miso);

    // R9: enables move only on a frame event or under soft reset
    a_r9_enable_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(func_en) |-> ($past(evt_valid) || $past(soft_rst)));

    // R11: soft reset forces enables low
    a_r11_enables_held: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (func_en == 9'd0));

    // R11: soft reset forces alarms clear
    a_r11_alarm_held: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !alarm_irq);

    // R8: an alarm can only appear after a frame event
    a_r8_alarm_from_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(evt_valid));

    // R12: conversion completes only while fully armed
    a_r12_done_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_done) |-> $past(adc_all_on));
endmodule

bind spi_rb_slave spi_rb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .evt_valid(evt_valid),
    .soft_rst(soft_rst), .adc_done(adc_done), .adc_all_on(adc_all_on),
    .alarm_irq(alarm_irq), .func_en(func_en)
);

// File: tb/spi_rb_slave_bench.sv
module spi_rb_slave_bench;
    localparam int         HALF = 6;
    localparam int         CONV = 500;
    localparam logic [3:0] REV  = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] det_level = 8'h00;
    logic [8:0] func_en;
    logic       alarm_irq;

    int n_cmp = 0, n_bad = 0, since_end = 0, cycles = 0;
    bit live = 1'b0;

    // behavioural reference state
    logic       m_par = 0, m_srst = 0, m_lo_sb = 0, m_done = 0;
    logic [3:0] m_alarm = 0, m_mask = 0, m_adcc = 0;
    logic [8:0] m_ena = 0;
    logic [7:0] m_lin = 0, m_lo_ph = 0, m_res = 0;

    spi_rb_slave #(.SYNC_STAGES(2), .REVISION(REV), .CONV_CYCLES(CONV)) u_spi_rb_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .det_level(det_level),
        .func_en(func_en), .alarm_irq(alarm_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (spi_cs_n) since_end++; else since_end = 0;
        if (live && since_end >= 12) begin
            check("R9 func_en per clock", {23'd0, func_en}, {23'd0, m_ena});
            check("R8 alarm_irq per clock", {31'd0, alarm_irq}, {31'd0, |(m_alarm & ~m_mask)});
        end
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic is_mapped(input logic [5:0] a);
        return (a <= 6'h06) || (a == 6'h0C);
    endfunction

    function automatic logic [15:0] m_view(input logic [5:0] a);
        case (a)
            6'h00: return {m_par, m_srst, 2'b00, 8'h0A, REV};
            6'h01: return {m_alarm, 12'h000};
            6'h02: return {m_mask, 12'h000};
            6'h03: return {7'd0, m_ena};
            6'h04: return {8'd0, m_lin};
            6'h05: return {5'd0, m_lo_sb, 2'b00, m_lo_ph};
            6'h06: return {12'd0, m_adcc};
            6'h0C: return {7'd0, m_done, m_res};
            default: return 16'h0000;
        endcase
    endfunction

    // odd-parity word
    function automatic logic [23:0] mk(input logic rd, input logic [5:0] a, input logic [15:0] d);
        logic [23:0] w;
        w = {rd, a, d, 1'b0};
        if (!(^w)) w[0] = 1'b1;
        return w;
    endfunction

    // kind: 0 complete, 1 short, 2 long
    task automatic model_apply(input int kind, input logic [23:0] w);
        logic old_srst, pb, rdf;
        logic [5:0] a;
        logic [15:0] d;
        old_srst = m_srst;
        rdf = w[23]; a = w[22:17]; d = w[16:1];
        pb = m_par && !(^w);
        if (kind == 0 && !pb && !rdf && a == 6'h00) {m_par, m_srst} = d[15:14];
        if (!old_srst) begin
            if (kind == 1) m_alarm[2] = 1'b1;
            else if (kind == 2) m_alarm[1] = 1'b1;
            else if (pb) m_alarm[3] = 1'b1;
            else if (!is_mapped(a)) m_alarm[0] = 1'b1;
            else if (!rdf) begin
                case (a)
                    6'h01: m_alarm = m_alarm & ~d[15:12];
                    6'h02: m_mask = d[15:12];
                    6'h03: m_ena = d[8:0];
                    6'h04: m_lin = d[7:0];
                    6'h05: begin m_lo_sb = d[10]; m_lo_ph = d[7:0]; end
                    6'h06: begin
                        if (m_adcc[2:0] != 3'b111 && d[2:0] == 3'b111) m_done = 1'b0;
                        m_adcc = d[3:0];
                    end
                    default: ;
                endcase
            end
        end
        if (m_srst) begin
            m_alarm = 0; m_mask = 0; m_ena = 0; m_lin = 0; m_lo_sb = 0;
            m_lo_ph = 0; m_adcc = 0; m_done = 0; m_res = 0;
        end
    endtask

    task automatic frame(input int nbits, input logic [23:0] w, output logic [15:0] got);
        got = '0;
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? w[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 7 && i <= 22) got[22-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        model_apply(nbits == 24 ? 0 : (nbits < 24 ? 1 : 2), w);
        repeat (16) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        logic [15:0] g;
        frame(24, mk(1'b0, a, d), g);
    endtask

    task automatic rd(input string tag, input logic [5:0] a);
        logic [15:0] g, e;
        e = is_mapped(a) ? m_view(a) : 16'h0000;
        frame(24, mk(1'b1, a, 16'h0000), g);
        check(tag, {16'd0, g}, {16'd0, e});
    endtask

    initial begin
        logic [15:0] g;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R14 func_en after reset", {23'd0, func_en}, 32'd0);
        check("R14 alarm_irq after reset", {31'd0, alarm_irq}, 32'd0);
        check("R14 miso after reset", {31'd0, spi_miso}, 32'd0);
        live = 1'b1;

        rd("R3 identity word", 6'h00);
        check("R3 identity constant", {16'd0, m_view(6'h00)}, 32'h00A3);
        rd("R14 alarm reset", 6'h01);
        rd("R14 mask reset", 6'h02);
        rd("R14 enable reset", 6'h03);
        rd("R14 linearizer reset", 6'h04);
        rd("R14 lo reset", 6'h05);
        rd("R14 adc ctrl reset", 6'h06);
        rd("R14 adc out reset", 6'h0C);

        // R1 R9 R10: normal writes and field layout
        wr(6'h03, 16'h01A5);  rd("R9 enable readback", 6'h03);
        wr(6'h04, 16'hFFC3);  rd("R10 linearizer field", 6'h04);
        wr(6'h05, 16'hFFFF);  rd("R10 lo path fields", 6'h05);
        check("R10 lo mask", {16'd0, m_view(6'h05)}, 32'h04FF);
        wr(6'h06, 16'hFFF8);  rd("R10 adc ctrl field", 6'h06);
        wr(6'h0C, 16'h01FF);  rd("R10 adc out not writable", 6'h0C);
        wr(6'h03, 16'h005A);  rd("R1 second data pattern", 6'h03);

        // R4 short frame (write of 0 to enable, 10 clocks)
        frame(10, mk(1'b0, 6'h03, 16'h0000), g);
        rd("R4 enable untouched after short", 6'h03);
        rd("R4 too-few flag", 6'h01);
        frame(0, 24'h0, g);
        rd("R4 zero-clock frame", 6'h01);

        // R5 long frame
        frame(25, mk(1'b0, 6'h03, 16'h0000), g);
        rd("R5 enable untouched after long", 6'h03);
        rd("R5 too-many flag", 6'h01);

        // R6 unmapped addresses
        wr(6'h09, 16'hFFFF);
        rd("R6 unmapped read returns zero", 6'h09);
        rd("R6 range flag", 6'h01);
        wr(6'h3F, 16'h1234);
        rd("R6 enable unchanged", 6'h03);

        // R8 mask and write-one-to-clear
        wr(6'h02, 16'h7000); rd("R8 mask readback", 6'h02);
        repeat (20) @(negedge clk);
        check("R8 irq masked", {31'd0, alarm_irq}, 32'd0);
        wr(6'h01, 16'h3000); rd("R8 partial clear", 6'h01);
        wr(6'h01, 16'hF000); rd("R8 full clear", 6'h01);
        wr(6'h02, 16'h0000);

        // R7 parity
        wr(6'h00, 16'h8000); rd("R7 parity enable set", 6'h00);
        begin
            logic [23:0] ev;
            ev = mk(1'b0, 6'h03, 16'h0111);
            ev[0] = ~ev[0];  // even number of ones
            frame(24, ev, g);
        end
        rd("R7 bad parity write dropped", 6'h03);
        rd("R7 parity flag", 6'h01);
        wr(6'h03, 16'h0111); rd("R7 good parity write lands", 6'h03);
        wr(6'h00, 16'h0000); wr(6'h01, 16'hF000);
        rd("R7 alarms cleared", 6'h01);

        // R9 power down
        wr(6'h03, 16'h0000); rd("R9 all functions off", 6'h03);
        check("R9 func_en zero", {23'd0, func_en}, 32'd0);

        // R11 soft reset
        wr(6'h03, 16'h00FF); wr(6'h04, 16'h0055);
        wr(6'h00, 16'h4000);
        check("R11 enables cleared", {23'd0, func_en}, 32'd0);
        wr(6'h03, 16'h0011);
        rd("R11 write ignored", 6'h03);
        frame(5, mk(1'b0, 6'h03, 16'h0000), g);
        rd("R11 no alarm recorded", 6'h01);
        rd("R11 control readable", 6'h00);
        wr(6'h00, 16'h0000);
        rd("R11 linearizer was cleared", 6'h04);

        // R12 R13 converter
        det_level = 8'h5C;
        wr(6'h06, 16'h0007);
        rd("R12 not done early", 6'h0C);
        repeat (CONV + 40) @(negedge clk);
        m_done = 1'b1; m_res = 8'h5C;
        rd("R12 done with result", 6'h0C);
        det_level = 8'h21;
        wr(6'h06, 16'h0003);
        rd("R13 result kept after stop", 6'h0C);
        wr(6'h06, 16'h0007);
        rd("R13 rearm clears done", 6'h0C);
        repeat (CONV + 40) @(negedge clk);
        m_done = 1'b1; m_res = 8'h21;
        rd("R12 second conversion", 6'h0C);

        repeat (20) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule